// File: doc/BRIEF.md
# Banked Interrupt Controller with Latched NMI

This block collects up to 81 interrupt sources into 32-bit banks and presents them to a processor as one IRQ line and one FIQ line. Every source has three control bits held in separate registers: a routing bit that sends it to IRQ or to FIQ, an enable bit, and a mask bit. A source drives an output only when it is enabled and not masked. Software reaches all of this through a plain 32-bit register port. A write strobe commits a write on the rising clock edge. Read data comes back one cycle after the address is presented.

Source 0 is different from the others. It is an external non-maskable-style input whose pending bit is a latch. A 2-bit mode field sets what arms the latch: low level, high level, falling edge or rising edge. Software clears the latch only by writing a one to its pending bit. The pending bits of sources 1 and up simply follow their input levels. A vector register combines a programmable base address with the number of the lowest-numbered active IRQ source, so a handler can branch or index without scanning the banks itself.

Top module: `banked_intc`

## Requirements
- R1: After reset, every enable bit reads 0. Every implemented mask bit reads 1. The protection register (0x08) reads 0x1 and the NMI mode register (0x0C) reads 0x0. Both irq_o and fiq_o are 0.
- R2: Source n sits at bit n%32 of bank n/32. Each bank register is at its group base + 4·bank: IRQ pending 0x10, FIQ pending 0x20, select 0x30, enable 0x40, mask 0x50. Bits for source numbers NUM_SRC and above read 0 and ignore writes. A bank index with no bank behind it reads 0.
- R3: A pending source affects irq_o, fiq_o or the vector only while its enable bit is 1 and its mask bit is 0.
- R4: A select bit of 1 routes the source to FIQ, so it appears in the FIQ pending bank and drives fiq_o. A select bit of 0 routes it to IRQ, the IRQ pending bank and irq_o. IRQ pending reads pending & ~select. FIQ pending reads pending & select.
- R5: The pending bits of sources 1 and up equal their input levels. Writes to the pending registers do not change them.
- R6: The vector register (0x00) reads base + 4·k, where k is the lowest-numbered enabled, unmasked, IRQ-routed pending source. It reads base unchanged when there is no such source.
- R7: The source 0 pending bit stays set until a write to 0x10 with bit 0 = 1. A write with bit 0 = 0 leaves it set. If the arming condition is present in the same cycle as the clearing write, the bit stays set.
- R8: NMI mode bits [1:0] at 0x0C: 00 arms on a low level, 01 on a high level, 10 on a falling edge, 11 on a rising edge.
- R9: irq_o and fiq_o are registered. They reflect the source inputs one clock edge after the inputs change. Read data is registered: it returns one edge after the address.
- R10: The base register (0x04) stores all 32 bits. The protection register stores bit 0 only. Both read back what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Source levels; bit 0 is the external NMI pin |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq_o | output | 1 | Registered IRQ request |
| fiq_o | output | 1 | Registered FIQ request |

## Verification
The main sweep raises each source from 1 to 80 on its own. This confirms the bank and bit mapping, the vector arithmetic and the one-edge output latency for every position, including the bank boundaries. A second sweep raises pairs of sources in which the higher number is spread pseudo-arithmetically. It shows that the lowest number always wins, whichever bank the higher source sits in. Sources at the bank edges are also tried under FIQ routing and under each enable/mask combination, which separates the routing path from the gating path. Each NMI mode is driven with both pin levels and both edges. A clearing write is issued during an active level to show that arming wins over clearing.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;

  localparam logic [3:0] GRP_CTRL  = 4'h0;
  localparam logic [3:0] GRP_IPEND = 4'h1;
  localparam logic [3:0] GRP_FPEND = 4'h2;
  localparam logic [3:0] GRP_SEL   = 4'h3;
  localparam logic [3:0] GRP_EN    = 4'h4;
  localparam logic [3:0] GRP_MASK  = 4'h5;

  typedef enum logic [1:0] {
    NMI_LOW  = 2'b00,
    NMI_HIGH = 2'b01,
    NMI_FALL = 2'b10,
    NMI_RISE = 2'b11
  } nmi_mode_e;
endpackage

// File: rtl/intc_nmi_cond.sv
module intc_nmi_cond
  import intc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pin_i,
  input  nmi_mode_e mode_i,
  input  logic      clr_i,
  output logic      set_o,
  output logic      pend_o
);
  logic prev_q;
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= pin_i;
  end

  always_comb begin
    unique case (mode_i)
      NMI_LOW:  set_o = ~pin_i;
      NMI_HIGH: set_o = pin_i;
      NMI_FALL: set_o = prev_q & ~pin_i;
      NMI_RISE: set_o = ~prev_q & pin_i;
      default:  set_o = 1'b0;
    endcase
  end

  // arming wins over a clearing write in the same cycle
  always_ff @(posedge clk) begin
    if (rst)        pend_q <= 1'b0;
    else if (set_o) pend_q <= 1'b1;
    else if (clr_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/intc_bank_regs.sv
module intc_bank_regs #(
  parameter int          W     = 32,
  parameter logic [31:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_sel,
  input  logic         we_en,
  input  logic         we_mask,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] sel_q,
  output logic [W-1:0] en_q,
  output logic [W-1:0] mask_q
);
  localparam logic [W-1:0] VMASK = VALID[W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      en_q   <= '0;
      mask_q <= VMASK;
    end else begin
      if (we_sel)  sel_q  <= wdata & VMASK;
      if (we_en)   en_q   <= wdata & VMASK;
      if (we_mask) mask_q <= wdata & VMASK;
    end
  end
endmodule

// File: rtl/intc_lowest.sv
module intc_lowest #(
  parameter int N     = 81,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/banked_intc.sv
module banked_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 81
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_we,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  output logic                irq_o,
  output logic                fiq_o
);
  localparam int BANKS = (NUM_SRC + REG_W - 1) / REG_W;
  localparam int FULL  = BANKS * REG_W;
  localparam int IDX_W = $clog2(NUM_SRC);

  function automatic logic [31:0] bank_valid(int b);
    logic [31:0] v;
    for (int k = 0; k < 32; k++) v[k] = ((b * 32 + k) < NUM_SRC);
    return v;
  endfunction

  logic [3:0] grp;
  logic [1:0] bnk;
  logic       bnk_ok;
  assign grp    = reg_addr[7:4];
  assign bnk    = reg_addr[3:2];
  assign bnk_ok = (int'(bnk) < BANKS);

  logic [BANKS-1:0][REG_W-1:0] pend_b, sel_b, en_b, mask_b;
  logic [FULL-1:0] pend_flat, sel_flat, en_flat, mask_flat;
  logic [FULL-1:0] active, irq_act, fiq_act;

  logic [REG_W-1:0] base_q;
  logic             prot_q;
  nmi_mode_e        nmi_mode_q;
  logic             nmi_clr, nmi_set, nmi_pend;

  assign nmi_clr = reg_we && (grp == GRP_IPEND) && (bnk == 2'd0) && reg_wdata[0];

  intc_nmi_cond u_nmi (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (src_i[0]),
    .mode_i (nmi_mode_q),
    .clr_i  (nmi_clr),
    .set_o  (nmi_set),
    .pend_o (nmi_pend)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    for (genvar k = 0; k < REG_W; k++) begin : g_bit
      if (b * REG_W + k == 0) begin : g_nmi
        assign pend_b[b][k] = nmi_pend;
      end else if (b * REG_W + k < NUM_SRC) begin : g_src
        assign pend_b[b][k] = src_i[b * REG_W + k];
      end else begin : g_none
        assign pend_b[b][k] = 1'b0;
      end
    end

    intc_bank_regs #(.W(REG_W), .VALID(bank_valid(b))) u_regs (
      .clk     (clk),
      .rst     (rst),
      .we_sel  (reg_we && grp == GRP_SEL  && bnk == 2'(b)),
      .we_en   (reg_we && grp == GRP_EN   && bnk == 2'(b)),
      .we_mask (reg_we && grp == GRP_MASK && bnk == 2'(b)),
      .wdata   (reg_wdata),
      .sel_q   (sel_b[b]),
      .en_q    (en_b[b]),
      .mask_q  (mask_b[b])
    );
  end

  assign pend_flat = pend_b;
  assign sel_flat  = sel_b;
  assign en_flat   = en_b;
  assign mask_flat = mask_b;

  assign active  = pend_flat & en_flat & ~mask_flat;
  assign irq_act = active & ~sel_flat;
  assign fiq_act = active & sel_flat;

  logic             low_found;
  logic [IDX_W-1:0] low_idx;

  intc_lowest #(.N(NUM_SRC), .IDX_W(IDX_W)) u_low (
    .req_i   (irq_act[NUM_SRC-1:0]),
    .found_o (low_found),
    .idx_o   (low_idx)
  );

  logic [REG_W-1:0] vector;
  assign vector = low_found ? (base_q + (REG_W'(low_idx) << 2)) : base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q     <= '0;
      prot_q     <= 1'b1;
      nmi_mode_q <= NMI_LOW;
    end else if (reg_we && grp == GRP_CTRL) begin
      case (bnk)
        2'd1:    base_q     <= reg_wdata;
        2'd2:    prot_q     <= reg_wdata[0];
        2'd3:    nmi_mode_q <= nmi_mode_e'(reg_wdata[1:0]);
        default: ;
      endcase
    end
  end

  logic [REG_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (grp)
      GRP_CTRL: begin
        case (bnk)
          2'd0:    rd_next = vector;
          2'd1:    rd_next = base_q;
          2'd2:    rd_next = {{(REG_W-1){1'b0}}, prot_q};
          default: rd_next = {{(REG_W-2){1'b0}}, nmi_mode_q};
        endcase
      end
      GRP_IPEND: if (bnk_ok) rd_next = pend_b[bnk] & ~sel_b[bnk];
      GRP_FPEND: if (bnk_ok) rd_next = pend_b[bnk] & sel_b[bnk];
      GRP_SEL:   if (bnk_ok) rd_next = sel_b[bnk];
      GRP_EN:    if (bnk_ok) rd_next = en_b[bnk];
      GRP_MASK:  if (bnk_ok) rd_next = mask_b[bnk];
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_o     <= 1'b0;
      fiq_o     <= 1'b0;
    end else begin
      reg_rdata <= rd_next;
      irq_o     <= |irq_act;
      fiq_o     <= |fiq_act;
    end
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 81
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    irq_o,
  input logic                    fiq_o,
  input logic                    nmi_clr,
  input logic                    nmi_set,
  input logic                    nmi_pend,
  input logic [((NUM_SRC+31)/32)*32-1:0] en_flat,
  input logic [((NUM_SRC+31)/32)*32-1:0] mask_flat
);
  localparam int FULL = ((NUM_SRC + 31) / 32) * 32;

  logic [FULL-1:0] valid_v;
  always_comb begin
    for (int i = 0; i < FULL; i++) valid_v[i] = (i < NUM_SRC);
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk) rst |=> (!irq_o && !fiq_o));

  // R7
  nmi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (nmi_pend && !nmi_clr) |=> nmi_pend);

  // R7
  nmi_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (nmi_clr && !nmi_set) |=> !nmi_pend);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((en_flat & ~valid_v) == '0));

  // R3
  gated_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((en_flat & ~mask_flat) == '0) |=> (!irq_o && !fiq_o));
endmodule

bind banked_intc intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .nmi_clr   (nmi_clr),
  .nmi_set   (nmi_set),
  .nmi_pend  (nmi_pend),
  .en_flat   (en_flat),
  .mask_flat (mask_flat)
);

// File: tb/banked_intc_tb.sv
module banked_intc_tb_top;
  localparam int N = 81;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] src = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o, fiq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  banked_intc #(.NUM_SRC(N)) dut_i (
    .clk(clk), .rst(rst), .src_i(src), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    tick();
    v = reg_rdata;
  endtask

  task automatic set_src(int n);
    src = N'(1);
    if (n > 0) src[n] = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    src[0] = 1'b1; // NMI pin inactive in default low-level mode
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 fiq", 32'(fiq_o), 0);
    for (int b = 0; b < 3; b++) begin
      rd(8'(8'h40 + 4*b), v); chk("R1 enable", v, 0);
      rd(8'(8'h50 + 4*b), v); chk("R1 mask", v, (b == 2) ? 32'h0001_FFFF : 32'hFFFF_FFFF);
    end
    rd(8'h08, v); chk("R1 prot", v, 1);
    rd(8'h0C, v); chk("R1 nmi mode", v, 0);

    // R2 reserved bits and absent bank; R10 storage
    wr(8'h48, 32'hFFFF_FFFF); rd(8'h48, v); chk("R2 reserved bits", v, 32'h0001_FFFF);
    wr(8'h4C, 32'hFFFF_FFFF); rd(8'h4C, v); chk("R2 absent bank", v, 0);
    wr(8'h04, BASE); rd(8'h04, v); chk("R10 base", v, BASE);
    wr(8'h08, 32'hFFFF_FFFE); rd(8'h08, v); chk("R10 prot", v, 0);
    wr(8'h08, 32'h1); rd(8'h08, v); chk("R10 prot", v, 1);

    // R5 pending not writable
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, v); chk("R5 write ignored", v, 0);

    for (int b = 0; b < 3; b++) begin
      wr(8'(8'h40 + 4*b), 32'hFFFF_FFFF);
      wr(8'(8'h50 + 4*b), 32'h0);
    end

    // Single-source sweep: R2 R5 R6 R9
    for (int n = 1; n < N; n++) begin
      set_src(0); tick();
      chk("R6 idle vector irq", 32'(irq_o), 0);
      set_src(n);
      #1 chk("R9 not yet", 32'(irq_o), 0);
      tick();
      chk("R9 irq after edge", 32'(irq_o), 1);
      chk("R4 fiq stays low", 32'(fiq_o), 0);
      rd(8'h00, v); chk("R6 vector single", v, BASE + 32'(4*n));
      rd(8'(8'h10 + 4*(n/32)), v); chk("R5 R2 pending map", v, 32'(1) << (n % 32));
    end

    // Pair sweep: R6 lowest wins
    for (int n = 1; n < N - 1; n++) begin
      int m;
      m = n + 1 + ((n * 13) % (N - 1 - n));
      src = N'(1); src[n] = 1'b1; src[m] = 1'b1;
      rd(8'h00, v); chk("R6 vector pair", v, BASE + 32'(4*n));
    end
    set_src(0); tick();
    rd(8'h00, v); chk("R6 vector idle", v, BASE);

    // R4 routing and R3 gating at bank edges
    for (int i = 0; i < 6; i++) begin
      int n, b;
      n = (i == 0) ? 1 : (i == 1) ? 31 : (i == 2) ? 32 : (i == 3) ? 63 : (i == 4) ? 64 : 80;
      b = n / 32;
      wr(8'(8'h30 + 4*b), 32'hFFFF_FFFF);
      set_src(n); tick();
      chk("R4 fiq routed", 32'(fiq_o), 1);
      chk("R4 irq quiet", 32'(irq_o), 0);
      rd(8'(8'h20 + 4*b), v); chk("R4 fiq pending", v, 32'(1) << (n % 32));
      rd(8'(8'h10 + 4*b), v); chk("R4 irq pending", v, 0);
      rd(8'h00, v); chk("R4 vector base", v, BASE);
      wr(8'(8'h30 + 4*b), 32'h0);
      wr(8'(8'h40 + 4*b), 32'h0); tick();
      chk("R3 disabled", 32'(irq_o), 0);
      wr(8'(8'h40 + 4*b), 32'hFFFF_FFFF);
      wr(8'(8'h50 + 4*b), 32'hFFFF_FFFF); tick();
      chk("R3 masked", 32'(irq_o), 0);
      rd(8'h00, v); chk("R3 masked vector", v, BASE);
      wr(8'(8'h50 + 4*b), 32'h0); tick();
      chk("R3 enabled unmasked", 32'(irq_o), 1);
      set_src(0); tick();
    end

    // NMI: R7 R8
    wr(8'h0C, 32'h3); rd(8'h0C, v); chk("R8 mode readback", v, 3);
    src[0] = 1'b0; tick(); tick();
    rd(8'h10, v); chk("R8 rise no set on fall", v, 0);
    src[0] = 1'b1; tick();
    rd(8'h10, v); chk("R8 rise sets", v, 1);
    chk("R7 nmi drives irq", 32'(irq_o), 1);
    rd(8'h00, v); chk("R6 nmi vector", v, BASE);
    src[0] = 1'b0; tick();
    wr(8'h10, 32'hFFFF_FFFE); rd(8'h10, v); chk("R7 write zero keeps", v, 1);
    wr(8'h10, 32'h1); rd(8'h10, v); chk("R7 write one clears", v, 0);

    wr(8'h0C, 32'h2);
    src[0] = 1'b1; tick(); tick();
    rd(8'h10, v); chk("R8 fall no set on rise", v, 0);
    src[0] = 1'b0; tick();
    rd(8'h10, v); chk("R8 fall sets", v, 1);
    wr(8'h10, 32'h1); rd(8'h10, v); chk("R7 clear after fall", v, 0);

    wr(8'h0C, 32'h1); tick();
    rd(8'h10, v); chk("R8 high idle", v, 0);
    src[0] = 1'b1; tick();
    rd(8'h10, v); chk("R8 high sets", v, 1);
    wr(8'h10, 32'h1); rd(8'h10, v); chk("R7 set wins over clear", v, 1);
    src[0] = 1'b0; tick();
    wr(8'h10, 32'h1); rd(8'h10, v); chk("R7 clear high", v, 0);

    wr(8'h0C, 32'h0); tick();
    rd(8'h10, v); chk("R8 low sets", v, 1);
    src[0] = 1'b1; tick();
    wr(8'h10, 32'h1); rd(8'h10, v); chk("R7 clear low", v, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule